// File: doc/BRIEF.md
# H5 Inverter Five-Switch Gate Sequencer

This block produces the five gate drives for one leg of a transformerless H5 inverter from a signed duty command. The duty sign picks the half-wave. In the positive half-wave one top switch is held on and its diagonal low switch is pulse-width modulated. In the negative half-wave the mirror pair takes over. A fifth switch sits in the DC link and separates the panel from the grid during freewheeling. It is modulated from the duty magnitude, and its turn-on and turn-off edges are moved by two signed offsets so that it can lead or lag the bridge switching.

The block follows a shared, centre-aligned PWM counter. That counter runs from -HALF up to HALF-1 and then wraps. The duty command and both offsets are taken into shadow registers only in the cycle where the counter shows -HALF, which marks the period boundary. Changing the inputs at any other time therefore cannot produce a glitch or a partial pulse. All gate outputs are registered.

Top module: `h5_gate_seq`

## Requirements
- R1: While `rst` is high, every bit of `gate_o` is 0.
- R2: In the positive half-wave, `gate_o[1]` is 1 and both `gate_o[2]` and `gate_o[3]` are 0.
- R3: In the positive half-wave, `gate_o[4]` is 1 exactly when the counter c satisfies -M <= c < M. Here M = floor(|duty| * HALF / 2^(DUTY_W-1)), and the duty is a two's-complement fraction.
- R4: In the negative half-wave, `gate_o[3]` is 1, both `gate_o[1]` and `gate_o[4]` are 0, and `gate_o[2]` is 1 exactly when -M <= c < M.
- R5: `gate_o[0]` is 1 exactly when M != 0 and LO <= c < HI. Here LO = -M - on_edge and HI = M - off_edge, with both offsets signed.
- R6: When M is 0, `gate_o[0]` stays low and the previous half-wave is kept. After reset the half-wave is positive. A nonzero M selects negative for a negative duty and positive otherwise.
- R7: The duty and both offsets are sampled only in a cycle where `pwm_cnt_i` equals -HALF. A change at any other cycle takes effect from the next period.
- R8: LO and HI are each clipped to the range [-HALF, HALF] before they are compared.
- R9: `gate_o` reflects the counter value that was presented two rising clock edges earlier.
- R10: Outside reset, `gate_o[1]` and `gate_o[3]` are never both 1, and `gate_o[2]` and `gate_o[4]` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| duty_i | input | DUTY_W | Signed duty fraction, full scale 2^(DUTY_W-1) |
| on_edge_i | input | CNT_W | Signed advance of the link-switch turn-on edge |
| off_edge_i | input | CNT_W | Signed advance of the link-switch turn-off edge |
| pwm_cnt_i | input | CNT_W | Shared signed PWM counter, -HALF to HALF-1 |
| gate_o | output | 5 | Gate drives; bit n drives switch Sn |

## Verification
The bench builds the block with HALF = 16, DUTY_W = 8 and CNT_W = 8, so one PWM period takes 32 cycles. With these values every counter position in many periods can be compared against a model. The small scale makes full-scale duty, offsets that drive both link-switch bounds into clipping, and a magnitude that truncates to zero cheap to reach. A stretch in which the duty changes on every cycle shows that only the value present at the boundary counts.

// File: rtl/h5g_pkg.sv
package h5g_pkg;

    typedef enum logic {
        HW_POS = 1'b0,
        HW_NEG = 1'b1
    } halfwave_e;

    // Bit position of each switch in the gate vector (bit n = switch Sn)
    localparam int IDX_LINK = 0;  // DC-link switch
    localparam int IDX_PTOP = 1;  // top switch held in positive half-wave
    localparam int IDX_NLOW = 2;  // low switch modulated in negative half-wave
    localparam int IDX_NTOP = 3;  // top switch held in negative half-wave
    localparam int IDX_PLOW = 4;  // low switch modulated in positive half-wave
    localparam int NUM_SW   = 5;

    // Clip a value into [-lim, lim]
    function automatic int clip_sym(input int v, input int lim);
        if (v > lim)       return lim;
        else if (v < -lim) return -lim;
        else               return v;
    endfunction

endpackage

// File: rtl/h5g_shadow.sv
module h5g_shadow
    import h5g_pkg::*;
#(
    parameter int CNT_W  = 14,
    parameter int DUTY_W = 16,
    parameter int HALF   = 3000
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load_i,
    input  logic signed [DUTY_W-1:0] duty_i,
    input  logic signed [CNT_W-1:0]  on_i,
    input  logic signed [CNT_W-1:0]  off_i,
    output halfwave_e                hw_o,
    output logic signed [CNT_W-1:0]  mag_o,
    output logic signed [CNT_W-1:0]  lo_o,
    output logic signed [CNT_W-1:0]  hi_o
);

    localparam int FRAC = DUTY_W - 1;

    typedef struct packed {
        halfwave_e               hw;
        logic signed [CNT_W-1:0] mag;
        logic signed [CNT_W-1:0] lo;
        logic signed [CNT_W-1:0] hi;
    } shadow_t;

    shadow_t sh_q, sh_d;
    int      abs_d, mag_n, lo_n, hi_n;

    // DUTY_W + log2(HALF) must stay below 31 for the product to fit an int
    always_comb begin
        abs_d = (duty_i < 0) ? -int'(duty_i) : int'(duty_i);
        mag_n = (abs_d * HALF) >>> FRAC;
        lo_n  = clip_sym(-mag_n - int'(on_i), HALF);
        hi_n  = clip_sym(mag_n - int'(off_i), HALF);
        sh_d  = sh_q;
        if (load_i) begin
            sh_d.mag = CNT_W'(mag_n);
            sh_d.lo  = CNT_W'(lo_n);
            sh_d.hi  = CNT_W'(hi_n);
            if (mag_n != 0)
                sh_d.hw = (duty_i < 0) ? HW_NEG : HW_POS;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q.hw  <= HW_POS;
            sh_q.mag <= '0;
            sh_q.lo  <= '0;
            sh_q.hi  <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign hw_o  = sh_q.hw;
    assign mag_o = sh_q.mag;
    assign lo_o  = sh_q.lo;
    assign hi_o  = sh_q.hi;

    // R7
    hw_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(sh_q));

    // R8
    bound_range_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(sh_q.lo) >= -HALF) && (int'(sh_q.lo) <= HALF) &&
        (int'(sh_q.hi) >= -HALF) && (int'(sh_q.hi) <= HALF));

endmodule

// File: rtl/h5g_window.sv
module h5g_window #(
    parameter int CNT_W = 14
) (
    input  logic                    en_i,
    input  logic signed [CNT_W-1:0] cnt_i,
    input  logic signed [CNT_W-1:0] lo_i,
    input  logic signed [CNT_W-1:0] hi_i,
    output logic                    hit_o
);

    always_comb hit_o = en_i && (cnt_i >= lo_i) && (cnt_i < hi_i);

endmodule

// File: rtl/h5_gate_seq.sv
module h5_gate_seq
    import h5g_pkg::*;
#(
    parameter int CNT_W  = 14,
    parameter int DUTY_W = 16,
    parameter int HALF   = 3000
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic signed [DUTY_W-1:0] duty_i,
    input  logic signed [CNT_W-1:0]  on_edge_i,
    input  logic signed [CNT_W-1:0]  off_edge_i,
    input  logic signed [CNT_W-1:0]  pwm_cnt_i,
    output logic [NUM_SW-1:0]        gate_o
);

    localparam logic signed [CNT_W-1:0] CNT_INIT = CNT_W'(-HALF);

    logic                    bnd;
    logic signed [CNT_W-1:0] cnt_q;
    halfwave_e               hw;
    logic signed [CNT_W-1:0] mag, lo0, hi0, br_lo;
    logic                    win_br, win_link;
    logic [NUM_SW-1:0]       gate_d, gate_q;

    assign bnd   = (pwm_cnt_i == CNT_INIT);
    assign br_lo = -mag;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= pwm_cnt_i;
    end

    h5g_shadow #(.CNT_W(CNT_W), .DUTY_W(DUTY_W), .HALF(HALF)) i_shadow (
        .clk    (clk),
        .rst    (rst),
        .load_i (bnd),
        .duty_i (duty_i),
        .on_i   (on_edge_i),
        .off_i  (off_edge_i),
        .hw_o   (hw),
        .mag_o  (mag),
        .lo_o   (lo0),
        .hi_o   (hi0)
    );

    h5g_window #(.CNT_W(CNT_W)) i_win_bridge (
        .en_i  (1'b1),
        .cnt_i (cnt_q),
        .lo_i  (br_lo),
        .hi_i  (mag),
        .hit_o (win_br)
    );

    h5g_window #(.CNT_W(CNT_W)) i_win_link (
        .en_i  (mag != '0),
        .cnt_i (cnt_q),
        .lo_i  (lo0),
        .hi_i  (hi0),
        .hit_o (win_link)
    );

    always_comb begin
        gate_d           = '0;
        gate_d[IDX_LINK] = win_link;
        if (hw == HW_POS) begin
            gate_d[IDX_PTOP] = 1'b1;
            gate_d[IDX_PLOW] = win_br;
        end else begin
            gate_d[IDX_NTOP] = 1'b1;
            gate_d[IDX_NLOW] = win_br;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) gate_q <= '0;
        else     gate_q <= gate_d;
    end

    assign gate_o = gate_q;

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (gate_o == '0));

    // R6
    link_zero_off_chk: assert property (@(posedge clk) disable iff (rst)
        (mag == '0) |=> !gate_o[IDX_LINK]);

    // R10
    top_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(gate_o[IDX_PTOP] && gate_o[IDX_NTOP]));

    // R10
    low_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(gate_o[IDX_NLOW] && gate_o[IDX_PLOW]));

    // R2
    pos_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        gate_o[IDX_PTOP] |-> (gate_o[IDX_NLOW] == 1'b0));

endmodule

// File: tb/test_h5_gate_seq.sv
`timescale 1ns/1ps
module test_h5_gate_seq;

    localparam int CW   = 8;
    localparam int DW   = 8;
    localparam int HALF = 16;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic signed [DW-1:0] duty = '0;
    logic signed [CW-1:0] on_e = '0;
    logic signed [CW-1:0] off_e = '0;
    logic signed [CW-1:0] cnt = '0;
    logic [4:0]           gate;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    int c_next = -HALF;
    int m_hw   = 0;
    int m_mag  = 0;
    int m_lo   = 0;
    int m_hi   = 0;
    logic [4:0] sb_q[$];

    always #10 clk = ~clk;

    h5_gate_seq #(.CNT_W(CW), .DUTY_W(DW), .HALF(HALF)) i_h5_gate_seq (
        .clk        (clk),
        .rst        (rst),
        .duty_i     (duty),
        .on_edge_i  (on_e),
        .off_edge_i (off_e),
        .pwm_cnt_i  (cnt),
        .gate_o     (gate)
    );

    function automatic int clipv(input int v);
        if (v > HALF) return HALF;
        if (v < -HALF) return -HALF;
        return v;
    endfunction

    // Monitor: compare the oldest expected item with the outputs (R9 latency)
    task automatic monitor_pop();
        logic [4:0] e;
        if (sb_q.size() < 2) return;
        e = sb_q.pop_front();
        n_chk++;
        if (gate !== e) begin
            n_fail++;
            if (gate[1] !== e[1] || gate[3] !== e[3])
                $display("FAIL R2/R4 top switches: got %b exp %b", gate, e);
            else if (gate[4] !== e[4])
                $display("FAIL R3 positive low switch: got %b exp %b", gate, e);
            else if (gate[2] !== e[2])
                $display("FAIL R4 negative low switch: got %b exp %b", gate, e);
            else
                $display("FAIL R5 link switch: got %b exp %b", gate, e);
        end
        n_chk++;
        if ((gate[1] && gate[3]) || (gate[2] && gate[4])) begin
            n_fail++;
            $display("FAIL R10 exclusion: got %b exp no overlapping pair", gate);
        end
    endtask

    // Driver: apply one cycle of stimulus and push the expected gate vector
    task automatic drive(input int d, input int on, input int off);
        logic [4:0] e;
        int ad;
        @(negedge clk);
        monitor_pop();
        duty  = DW'(d);
        on_e  = CW'(on);
        off_e = CW'(off);
        cnt   = CW'(c_next);
        if (c_next == -HALF) begin  // R7: load only at the boundary
            ad    = (int'(duty) < 0) ? -int'(duty) : int'(duty);
            m_mag = (ad * HALF) / (1 << (DW - 1));
            m_lo  = clipv(-m_mag - on);   // R8
            m_hi  = clipv(m_mag - off);   // R8
            if (m_mag != 0) m_hw = (int'(duty) < 0) ? 1 : 0;  // R6
        end
        e = '0;
        if (m_hw == 0) begin
            e[1] = 1'b1;
            e[4] = (c_next >= -m_mag) && (c_next < m_mag);
        end else begin
            e[3] = 1'b1;
            e[2] = (c_next >= -m_mag) && (c_next < m_mag);
        end
        e[0] = (m_mag != 0) && (c_next >= m_lo) && (c_next < m_hi);
        sb_q.push_back(e);
        c_next = (c_next == HALF - 1) ? -HALF : c_next + 1;
    endtask

    task automatic run_periods(input int d, input int on, input int off, input int np);
        for (int i = 0; i < np * 2 * HALF; i++) drive(d, on, off);
    endtask

    task automatic finish_run();
        if (done) return;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout exp completion");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        n_chk++;  // R1
        if (gate !== 5'b0) begin
            n_fail++;
            $display("FAIL R1 reset: got %b exp 00000", gate);
        end
        rst = 1'b0;
        c_next = -HALF;
        // R6: zero duty right after reset keeps positive half-wave, link off
        run_periods(0, 0, 0, 1);
        // R2 R3 R5: positive half-wave with offsets
        run_periods(64, 2, 1, 3);
        // R4: negative half-wave
        run_periods(-96, 0, 0, 3);
        // R6: zero keeps the negative half-wave
        run_periods(0, 3, 3, 2);
        // R8: full negative scale with clipping on both bounds
        run_periods(-128, 5, -3, 2);
        // R3: largest positive code
        run_periods(127, -2, 4, 2);
        // R6: tiny duty truncates to zero after a positive period
        run_periods(1, 0, 0, 2);
        // R7: inputs change every cycle, only boundary values count
        for (int i = 0; i < 6 * 2 * HALF; i++)
            drive($signed(DW'($urandom)), int'($urandom % 9) - 4, int'($urandom % 9) - 4);
        run_periods(-40, -6, 6, 2);
        drive(0, 0, 0);
        drive(0, 0, 0);
        finish_run();
    end

endmodule